// File: doc/BRIEF.md
# Serial ADC Output Framer

This block is the digital back end of a multi-channel sampling converter. It takes one sample per channel for each byte slot, turns each sample into an output code, and shifts every channel out MSB first on its own serial lane. All channels share one data clock and one frame marker. The block runs on a bit clock `clk` at eight times the sample rate, so one bit leaves per `clk` cycle. The data clock output `bitclk_o` toggles on every `clk` edge and so runs at four times the sample rate. Each lane bit changes together with a rising or a falling transition of `bitclk_o`. The frame output `frame_o` is high for the first half of each byte and low for the second half.

Samples arrive on a valid/ready stream. A transfer happens on a rising edge of `clk` where `s_valid` and `s_ready` are both high. `s_ready` is high only when the lock is present, the restart gap has elapsed, and either no byte is in flight or the last bit of the current byte is on the lanes. A sample offered in that last-bit cycle goes out back to back with no gap. If nothing is offered, the lanes pause at a byte boundary. The upstream side may hold `s_valid` high for as long as it likes, and the data is taken only on a handshake. The raw input is offset binary. A per-channel clip flag forces the code to all ones or all zeros, and `twos_sel` picks two's complement output by inverting the MSB.

`pll_lock_n` is active low: high means the clock source is unlocked. While it is high, every output freezes and the byte in flight is dropped. When lock returns, the data clock runs for `RESYNC` cycles before the first new byte, and that byte is marked by a rising `frame_o`.

Top module: `adc_serial_framer`

## Requirements
- R1: While `rst_n` is low, all lanes, `bitclk_o`, `frame_o` and all `clip_o` bits are 0, and `s_ready` is 0.
- R2: A sample vector is taken on a rising `clk` edge with `s_valid` and `s_ready` both high. `s_ready` is high only when locked, past the restart gap, and either idle or showing the last bit of a byte. Each taken sample appears exactly once, in order, and no byte appears without a transfer.
- R3: From the edge after a transfer, each lane carries the W-bit code of its channel, MSB first, one bit per `clk` cycle. Channel i uses `s_data[i*W +: W]`. `bitclk_o` toggles on every `clk` edge while locked.
- R4: `frame_o` rises on the first bit of every byte and only there. It stays high for bits W-1 down to W/2 and is low for the remaining W/2 bits.
- R5: When `twos_sel`=1, the code is the offset-binary value with its MSB inverted (0x00 gives 0x80, 0xFF gives 0x7F). When `twos_sel`=0, the code is the raw value.
- R6: When `s_clip[i]`=1, channel i's value is replaced before formatting by all ones if `s_clip_hi[i]`=1, or by all zeros otherwise. `clip_o[i]` takes `s_clip[i]` at the transfer and holds it until the next transfer.
- R7: While `pll_lock_n` is high, `s_ready` is 0 and the lanes, `bitclk_o`, `frame_o` and `clip_o` keep their values.
- R8: If lock is lost while a byte is in flight, the rest of that byte is never sent. After lock returns, that byte is not resumed.
- R9: After `pll_lock_n` falls, `bitclk_o` toggles for RESYNC cycles with `frame_o` low and `s_ready` low. Only then can a new byte start.
- R10: With no transfer at a byte boundary, the lanes hold their last bit, `frame_o` is low and `bitclk_o` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, eight times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_lock_n | input | 1 | Active-low lock status; high freezes output |
| twos_sel | input | 1 | 1: two's complement output, 0: offset binary |
| s_valid | input | 1 | Sample vector offered |
| s_ready | output | 1 | Framer can take a sample vector on this edge |
| s_data | input | NCH*W | Offset-binary samples, channel i at bits i*W +: W |
| s_clip | input | NCH | Per-channel out-of-range flag |
| s_clip_hi | input | NCH | Clip direction: 1 gives all ones, 0 gives all zeros |
| lane_o | output | NCH | Serial data lane per channel |
| bitclk_o | output | 1 | Data clock at four times the sample rate |
| frame_o | output | 1 | Byte frame marker |
| clip_o | output | NCH | Out-of-range flag of the byte being sent |

## Verification
The hardest case to reach is a lock loss while a byte is partly out, followed by a relock. Here the frozen bits, the abandoned tail, the restart gap and the next frame-marked byte must all line up. The bench drives this case directly: it drops the lock three bits into a byte, holds it off, and checks `s_ready` through the gap. Random lock drops during back-to-back random traffic then reach the same case at other bit positions. A bench deserializer rebuilds bytes from frame rises and dco transitions, so any resumed tail shows up as a data mismatch against the next queued sample.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // sequencer phases: restart gap, idle at byte boundary, sending a byte
  typedef enum logic [1:0] {
    SQ_SYNC = 2'd0,
    SQ_IDLE = 2'd1,
    SQ_SEND = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sfr_fmt.sv
module sfr_fmt #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  input  logic         clip,
  input  logic         clip_hi,
  input  logic         twos,
  output logic [W-1:0] code
);
  logic [W-1:0] clamped;

  always_comb begin
    clamped = clip ? {W{clip_hi}} : raw;
    code    = clamped;
    code[W-1] = clamped[W-1] ^ twos;
  end
endmodule

// File: rtl/sfr_lane.sv
module sfr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] code,
  input  logic         clip_in,
  output logic         bit_o,
  output logic         clip_o
);
  logic [W-2:0] rest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_o  <= 1'b0;
      rest   <= '0;
      clip_o <= 1'b0;
    end else if (load) begin
      bit_o  <= code[W-1];
      rest   <= code[W-2:0];
      clip_o <= clip_in;
    end else if (shift) begin
      bit_o <= rest[W-2];
      rest  <= {rest[W-3:0], 1'b0};
    end
  end
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int W      = 8,
  parameter int RESYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_n,
  input  logic s_valid,
  output logic s_ready,
  output logic load,
  output logic shift,
  output logic dco,
  output logic fco
);
  localparam int HALF = W / 2;
  localparam int CW   = $clog2(W);
  localparam int RW   = $clog2(RESYNC + 1);

  sq_state_e   st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rs;
  logic          last;

  always_comb begin
    last    = (cnt == CW'(W - 1));
    s_ready = !lock_n && ((st == SQ_IDLE) || (st == SQ_SEND && last));
    load    = s_ready && s_valid;
    shift   = !lock_n && (st == SQ_SEND) && !last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_SYNC;
      cnt <= '0;
      rs  <= RW'(RESYNC);
      dco <= 1'b0;
      fco <= 1'b0;
    end else if (lock_n) begin
      // frozen: outputs hold, byte in flight dropped
      st <= SQ_SYNC;
      rs <= RW'(RESYNC);
    end else begin
      dco <= ~dco;
      unique case (st)
        SQ_SYNC: begin
          fco <= 1'b0;
          if (rs <= RW'(1)) st <= SQ_IDLE;
          else              rs <= rs - RW'(1);
        end
        SQ_IDLE: begin
          if (load) begin
            st  <= SQ_SEND;
            cnt <= '0;
            fco <= 1'b1;
          end else begin
            fco <= 1'b0;
          end
        end
        SQ_SEND: begin
          if (last) begin
            if (load) begin
              cnt <= '0;
              fco <= 1'b1;
            end else begin
              st  <= SQ_IDLE;
              fco <= 1'b0;
            end
          end else begin
            cnt <= cnt + CW'(1);
            fco <= (cnt < CW'(HALF - 1));
          end
        end
        default: st <= SQ_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer #(
  parameter int NCH    = 4,
  parameter int W      = 8,
  parameter int RESYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pll_lock_n,
  input  logic           twos_sel,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [NCH*W-1:0] s_data,
  input  logic [NCH-1:0] s_clip,
  input  logic [NCH-1:0] s_clip_hi,
  output logic [NCH-1:0] lane_o,
  output logic           bitclk_o,
  output logic           frame_o,
  output logic [NCH-1:0] clip_o
);
  logic load;
  logic shift;

  sfr_seq #(.W(W), .RESYNC(RESYNC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_n  (pll_lock_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .load    (load),
    .shift   (shift),
    .dco     (bitclk_o),
    .fco     (frame_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] code;

    sfr_fmt #(.W(W)) u_fmt (
      .raw     (s_data[i*W +: W]),
      .clip    (s_clip[i]),
      .clip_hi (s_clip_hi[i]),
      .twos    (twos_sel),
      .code    (code)
    );

    sfr_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (shift),
      .code    (code),
      .clip_in (s_clip[i]),
      .bit_o   (lane_o[i]),
      .clip_o  (clip_o[i])
    );
  end
endmodule

// File: rtl/adc_serial_framer_chk.sv
module adc_serial_framer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pll_lock_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic [NCH-1:0] lane_o,
  input logic           bitclk_o,
  input logic           frame_o,
  input logic [NCH-1:0] clip_o
);
  AST_HOLD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lock_n |=> ($stable(lane_o) && $stable(bitclk_o) && $stable(frame_o) && $stable(clip_o))); // R7
  AST_NO_ACCEPT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_lock_n |-> !s_ready); // R7
  AST_DCO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock_n |=> (bitclk_o != $past(bitclk_o))); // R3
  AST_FRAME_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> $rose(frame_o)); // R4
  AST_FRAME_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> $past(s_valid && s_ready)); // R4
  AST_RESYNC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_lock_n) |-> !s_ready); // R9
  AST_CLIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(s_valid && s_ready) |-> $stable(clip_o)); // R6
endmodule

bind adc_serial_framer adc_serial_framer_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_lock_n (pll_lock_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .lane_o     (lane_o),
  .bitclk_o   (bitclk_o),
  .frame_o    (frame_o),
  .clip_o     (clip_o)
);

// File: tb/adc_serial_framer_test.sv
module adc_serial_framer_test;
  localparam int NCH  = 4;
  localparam int W    = 8;
  localparam int HALF = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_lock_n = 1'b0;
  logic twos_sel = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [NCH*W-1:0] s_data = '0;
  logic [NCH-1:0] s_clip = '0;
  logic [NCH-1:0] s_clip_hi = '0;
  logic [NCH-1:0] lane_o;
  logic bitclk_o;
  logic frame_o;
  logic [NCH-1:0] clip_o;

  always #2.5 clk = ~clk;

  adc_serial_framer #(.NCH(NCH), .W(W), .RESYNC(2)) uut (
    .clk(clk), .rst_n(rst_n), .pll_lock_n(pll_lock_n), .twos_sel(twos_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_clip(s_clip),
    .s_clip_hi(s_clip_hi), .lane_o(lane_o), .bitclk_o(bitclk_o),
    .frame_o(frame_o), .clip_o(clip_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [NCH*W-1:0] q_dat[$];
  logic [NCH-1:0]   q_clp[$];

  // monitor state
  bit live = 0;
  bit lk_edge = 0;
  int n = 0;
  logic [W-1:0] acc [NCH];
  logic [NCH-1:0] p_lane = '0;
  logic p_dco = 0, p_fco = 0, p_slot_fco = 0;
  logic [NCH-1:0] p_clip = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_code(logic [W-1:0] raw, logic c, logic hi, logic tw);
    logic [W-1:0] v;
    v = c ? {W{hi}} : raw;
    v[W-1] = v[W-1] ^ tw;
    return v;
  endfunction

  task automatic monitor();
    if (live && lk_edge) begin
      chk(lane_o == p_lane && bitclk_o == p_dco && frame_o == p_fco && clip_o == p_clip,
          "R7", "outputs frozen while unlocked", {lane_o, bitclk_o, frame_o}, {p_lane, p_dco, p_fco});
      if (n > 0 && n < W) begin
        chk(q_dat.size() > 0, "R8", "abandoned byte present", q_dat.size(), 1);
        if (q_dat.size() > 0) begin void'(q_dat.pop_front()); void'(q_clp.pop_front()); end
        n = 0;
      end
    end else if (live) begin
      chk(bitclk_o != p_dco, "R3", "dco toggles while locked", bitclk_o, !p_dco);
      if (frame_o && !p_slot_fco) begin
        chk(n == 0, "R4", "frame rise only at byte start", n, 0);
        chk(q_dat.size() > 0, "R2", "byte has a transfer", q_dat.size(), 1);
        if (q_dat.size() > 0)
          chk(clip_o == q_clp[0], "R6", "clip flag with byte", clip_o, q_clp[0]);
        for (int c = 0; c < NCH; c++) acc[c] = {{(W-1){1'b0}}, lane_o[c]};
        n = 1;
      end else if (n > 0) begin
        chk(frame_o == (n < HALF), "R4", "frame level in byte", frame_o, (n < HALF));
        for (int c = 0; c < NCH; c++) acc[c] = {acc[c][W-2:0], lane_o[c]};
        n++;
        if (n == W) begin
          if (q_dat.size() > 0) begin
            for (int c = 0; c < NCH; c++)
              chk(acc[c] == q_dat[0][c*W +: W], "R3 R5 R6", "lane byte", acc[c], q_dat[0][c*W +: W]);
            void'(q_dat.pop_front()); void'(q_clp.pop_front());
          end
          n = 0;
        end
      end else begin
        chk(!frame_o && lane_o == p_lane, "R10", "idle slot holds lanes, frame low",
            {frame_o, lane_o}, {1'b0, p_lane});
      end
      p_slot_fco = frame_o;
    end
    p_lane = lane_o; p_dco = bitclk_o; p_fco = frame_o; p_clip = clip_o;
  endtask

  task automatic cyc_d(bit v, bit lk, logic [NCH*W-1:0] raw, logic [NCH-1:0] c, logic [NCH-1:0] hi);
    logic [NCH*W-1:0] e;
    @(negedge clk);
    monitor();
    s_valid = v; pll_lock_n = lk; s_data = raw; s_clip = c; s_clip_hi = hi;
    #1;
    if (lk) chk(!s_ready, "R7", "no ready while unlocked", s_ready, 0);
    if (s_valid && s_ready) begin
      for (int k = 0; k < NCH; k++)
        e[k*W +: W] = exp_code(raw[k*W +: W], c[k], hi[k], twos_sel);
      q_dat.push_back(e); q_clp.push_back(c);
    end
    lk_edge = lk;
    live = rst_n;
  endtask

  task automatic cyc_r(bit v, bit lk);
    logic [NCH*W-1:0] raw;
    logic [NCH-1:0] c, hi;
    for (int k = 0; k < NCH; k++) begin
      raw[k*W +: W] = W'($urandom);
      c[k]  = ($urandom % 10) == 0;
      hi[k] = $urandom % 2;
    end
    cyc_d(v, lk, raw, c, hi);
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_dat.size() > 0 || n != 0) && guard < 100) begin cyc_r(0, 0); guard++; end
    for (int k = 0; k < 4; k++) cyc_r(0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lane_o == '0 && bitclk_o == 0 && frame_o == 0 && clip_o == '0, "R1", "reset outputs",
        {lane_o, bitclk_o, frame_o, clip_o}, 0);
    chk(!s_ready, "R1", "ready low in reset", s_ready, 0);
    p_lane = lane_o; p_dco = bitclk_o; p_fco = frame_o; p_clip = clip_o;
    rst_n = 1'b1;
    cyc_d(0, 0, '0, '0, '0);
    chk(!s_ready, "R9", "gap after reset", s_ready, 0);
    cyc_d(0, 0, '0, '0, '0);
    chk(s_ready, "R2", "ready after gap", s_ready, 1);

    // R5 offset binary, then directed clamps R6
    cyc_d(1, 0, {8'h3C, 8'hFF, 8'h00, 8'hA5}, '0, '0);
    cyc_d(0, 0, '0, '0, '0);
    for (int k = 0; k < W-2; k++) begin
      cyc_d(0, 0, '0, '0, '0);
      chk(!s_ready, "R2", "busy mid-byte", s_ready, 0);
    end
    cyc_d(1, 0, {8'h12, 8'h34, 8'h56, 8'h78}, 4'b1010, 4'b1000);
    drain();
    twos_sel = 1'b1;
    cyc_d(1, 0, {8'h3C, 8'hFF, 8'h00, 8'hA5}, '0, '0);
    for (int k = 0; k < W-1; k++) cyc_d(0, 0, '0, '0, '0);
    cyc_d(1, 0, {8'h11, 8'h22, 8'h33, 8'h44}, 4'b0011, 4'b0001);
    drain();

    // R8 R9 lock lost mid-byte, then relock
    cyc_d(1, 0, {8'hDE, 8'hAD, 8'hBE, 8'hEF}, '0, '0);
    for (int k = 0; k < 3; k++) cyc_d(0, 0, '0, '0, '0);
    for (int k = 0; k < 4; k++) cyc_d(0, 1, '0, '0, '0);
    cyc_d(0, 0, '0, '0, '0);
    chk(!s_ready, "R9", "ready low at relock", s_ready, 0);
    cyc_d(0, 0, '0, '0, '0);
    chk(!s_ready, "R9", "ready low in gap", s_ready, 0);
    cyc_d(1, 0, {8'h01, 8'h80, 8'h7F, 8'hC3}, '0, '0);
    chk(s_ready, "R9", "ready after gap", s_ready, 1);
    drain();
    chk(q_dat.size() == 0, "R8", "no leftover bytes", q_dat.size(), 0);

    // random traffic with random lock drops, both formats
    for (int ph = 0; ph < 2; ph++) begin
      twos_sel = ph[0];
      for (int i = 0; i < 3000; i++) begin
        if ($urandom % 250 == 0) begin
          int len = 1 + $urandom % 8;
          for (int k = 0; k < len; k++) cyc_r($urandom % 2, 1);
        end else begin
          cyc_r(($urandom % 4) != 0, 0);
        end
      end
      drain();
    end
    chk(q_dat.size() == 0, "R2", "all transfers delivered", q_dat.size(), 0);
    summary();
  end
endmodule